// File: doc/BRIEF.md
# Transfer Record List Sequencer

This block steps through the ordered list of transfer records held inside one record-list descriptor. A single start pulse supplies three things: the first header word of the descriptor, the record-size code taken from the second header word, and the descriptor base address. The block then requests the records one at a time on a ready/valid fetch port. With each request it gives the record's memory address and the address of that record's response slot.

After a fetch is accepted, the block waits for the executing engine to signal on a record-done handshake that the record is finished. It then moves to the next index. When the final index of a pass completes, one of three things happens:
- If the reload budget is not spent, the block vectors back to a programmable reload index.
- If the reload count is the all-ones value, it keeps looping without end.
- Otherwise it finishes and pulses a completion strobe, so the descriptor can be handed to its return queue.

A header that does not describe a record list is refused with a one-cycle error pulse.

Top module: `trs_list_seq`

## Requirements
- R1: After synchronous reset, `busy`, `fetch_valid`, `rec_done_ready`, `list_done` and `list_err` are all low.
- R2: A start in idle with header bits 31:30 equal to 3, bit 29 zero and `size_code` at most 3 begins the list at index 0. Record k is requested at `desc_base + S*(k+1)`, where S = 16 << `size_code` (0:16 B, 1:32 B, 2:64 B, 3:128 B).
- R3: While a record k is requested, `resp_addr` equals `desc_base + S*(L+2) + 4*k`, where L is the last-index field in header bits 13:0.
- R4: A pending fetch request keeps its address stable until `fetch_ready`. Only one record is in flight at a time: after a fetch is accepted, `fetch_valid` stays low and `rec_done_ready` is high until the record-done handshake.
- R5: Within a pass, indices are requested in ascending order, each one after the previous record's done handshake, up to and including L.
- R6: When record L completes and the reload count in bits 28:20 is neither 0 nor 0x1FF, the block jumps to the reload index in bits 19:14. It does this exactly that many times, and the reload index is never used on the first pass. When the remaining count is 0, the list finishes.
- R7: A reload count of 0x1FF repeats the reload pass indefinitely, and `list_done` is never raised.
- R8: `list_done` is high for exactly one cycle, the cycle after the done handshake of the final record of the final pass, and `busy` is low in that cycle.
- R9: A start with bits 31:30 not equal to 3, bit 29 set, or `size_code` above 3 raises `list_err` for one cycle on the next cycle and issues no fetch.
- R10: A start while `busy` is high is ignored: no error pulse, and the list in progress continues at its own addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, sampled in idle |
| hdr_w0 | input | 32 | First descriptor header word |
| size_code | input | 3 | Record-size code from the second header word |
| desc_base | input | ADDR_W | Descriptor base address |
| fetch_valid | output | 1 | Record fetch request |
| fetch_ready | input | 1 | Fetch request accepted |
| fetch_addr | output | ADDR_W | Address of the requested record |
| fetch_idx | output | 14 | Index of the requested record |
| resp_addr | output | ADDR_W | Response slot address of the requested record |
| rec_done_valid | input | 1 | Record finished |
| rec_done_ready | output | 1 | Waiting for the record-done handshake |
| busy | output | 1 | A list is in progress |
| list_done | output | 1 | One-cycle completion pulse |
| list_err | output | 1 | One-cycle header rejection pulse |

## Verification
The hardest state to reach from the ports is the moment the final record of a reload pass completes. The remaining reload count then decides between jumping and finishing, and the 0x1FF case must never decide to finish. To get there, the stimulus runs lists whose reload index is both zero and non-zero, and one whose reload index equals the last index. It uses counts of 0, 1, 2 and 3, and one endless list that is serviced for three passes and then cut off by reset. A stray start is injected in the middle of a list, and handshake gaps are varied, so that stability and exclusivity of the fetch and done phases are exercised under stalls.

// File: rtl/trs_pkg.sv
package trs_pkg;

    localparam int IDX_W   = 14;
    localparam int RIDX_W  = 6;
    localparam int RCNT_W  = 9;
    localparam int SZC_W   = 3;
    localparam logic [1:0]        KIND_RECLIST = 2'd3;
    localparam logic [RCNT_W-1:0] RCNT_ENDLESS = '1;

    // layout of the first header word, most significant field first
    typedef struct packed {
        logic [1:0]        kind;
        logic              rsvd;
        logic [RCNT_W-1:0] rcnt;
        logic [RIDX_W-1:0] ridx;
        logic [IDX_W-1:0]  last;
    } hdr0_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FETCH = 2'd1,
        S_WAIT  = 2'd2
    } seq_state_t;

    // log2 of the record size in bytes
    function automatic logic [2:0] rec_shift(input logic [1:0] code);
        return 3'd4 + {1'b0, code};
    endfunction

    function automatic logic hdr_ok(input hdr0_t h, input logic [SZC_W-1:0] code);
        return (h.kind == KIND_RECLIST) && !h.rsvd && (code <= 3'd3);
    endfunction

endpackage

// File: rtl/trs_addr.sv
module trs_addr
    import trs_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    input  logic [IDX_W-1:0]  last,
    input  logic [1:0]        code,
    output logic [ADDR_W-1:0] rec_addr,
    output logic [ADDR_W-1:0] rsp_addr
);

    localparam int SUM_W = IDX_W + 1;

    logic [2:0]        sh;
    logic [SUM_W-1:0]  slot_rec;
    logic [SUM_W-1:0]  slot_rsp;
    logic [ADDR_W-1:0] rec_off;
    logic [ADDR_W-1:0] rsp_off;

    always_comb begin
        sh       = rec_shift(code);
        // slot 0 holds the packet info header
        slot_rec = {1'b0, idx} + SUM_W'(1);
        // responses follow all (last+1) records plus the header slot
        slot_rsp = {1'b0, last} + SUM_W'(2);
        rec_off  = ADDR_W'(slot_rec) << sh;
        rsp_off  = (ADDR_W'(slot_rsp) << sh) + (ADDR_W'(idx) << 2);
        rec_addr = base + rec_off;
        rsp_addr = base + rsp_off;
    end

endmodule

// File: rtl/trs_reload.sv
module trs_reload
    import trs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [RCNT_W-1:0] load_cnt,
    input  logic              take,
    output logic              may_jump
);

    logic [RCNT_W-1:0] left;
    logic              endless;

    assign endless  = (left == RCNT_ENDLESS);
    assign may_jump = endless || (left != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
        end else if (load) begin
            left <= load_cnt;
        end else if (take && !endless) begin
            left <= left - RCNT_W'(1);
        end
    end

endmodule

// File: rtl/trs_list_seq.sv
module trs_list_seq
    import trs_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [31:0]       hdr_w0,
    input  logic [2:0]        size_code,
    input  logic [ADDR_W-1:0] desc_base,
    output logic              fetch_valid,
    input  logic              fetch_ready,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [13:0]       fetch_idx,
    output logic [ADDR_W-1:0] resp_addr,
    input  logic              rec_done_valid,
    output logic              rec_done_ready,
    output logic              busy,
    output logic              list_done,
    output logic              list_err
);

    hdr0_t             hdr;
    seq_state_t        state;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  last;
    logic [RIDX_W-1:0] ridx;
    logic [1:0]        code;
    logic [ADDR_W-1:0] base;
    logic              done_q;
    logic              err_q;

    logic hdr_good;
    logic launch;
    logic rec_fin;
    logic at_last;
    logic may_jump;
    logic jump;

    assign hdr      = hdr0_t'(hdr_w0);
    assign hdr_good = hdr_ok(hdr, size_code);
    assign launch   = (state == S_IDLE) && start && hdr_good;
    assign rec_fin  = (state == S_WAIT) && rec_done_valid;
    assign at_last  = (idx >= last);
    assign jump     = rec_fin && at_last && may_jump;

    trs_reload i_reload (
        .clk      (clk),
        .rst      (rst),
        .load     (launch),
        .load_cnt (hdr.rcnt),
        .take     (jump),
        .may_jump (may_jump)
    );

    trs_addr #(.ADDR_W(ADDR_W)) i_addr (
        .base     (base),
        .idx      (idx),
        .last     (last),
        .code     (code),
        .rec_addr (fetch_addr),
        .rsp_addr (resp_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            idx    <= '0;
            last   <= '0;
            ridx   <= '0;
            code   <= '0;
            base   <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        if (hdr_good) begin
                            idx   <= '0;
                            last  <= hdr.last;
                            ridx  <= hdr.ridx;
                            code  <= size_code[1:0];
                            base  <= desc_base;
                            state <= S_FETCH;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                S_FETCH: begin
                    if (fetch_ready) begin
                        state <= S_WAIT;
                    end
                end
                S_WAIT: begin
                    if (rec_done_valid) begin
                        if (!at_last) begin
                            idx   <= idx + IDX_W'(1);
                            state <= S_FETCH;
                        end else if (may_jump) begin
                            idx   <= IDX_W'(ridx);
                            state <= S_FETCH;
                        end else begin
                            done_q <= 1'b1;
                            state  <= S_IDLE;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign fetch_valid    = (state == S_FETCH);
    assign rec_done_ready = (state == S_WAIT);
    assign busy           = (state != S_IDLE);
    assign fetch_idx      = idx;
    assign list_done      = done_q;
    assign list_err       = err_q;

endmodule

// File: rtl/trs_list_seq_chk.sv
module trs_list_seq_chk #(
    parameter int ADDR_W = 40
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              fetch_valid,
    input logic              fetch_ready,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic [ADDR_W-1:0] resp_addr,
    input logic              rec_done_valid,
    input logic              rec_done_ready,
    input logic              busy,
    input logic              list_done,
    input logic              list_err
);

    // R4
    fetch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_valid && !fetch_ready |=> fetch_valid && $stable(fetch_addr) && $stable(resp_addr));

    // R4
    one_phase_chk: assert property (@(posedge clk) disable iff (rst)
        !(fetch_valid && rec_done_ready));

    // R4
    wait_after_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_valid && fetch_ready |=> rec_done_ready && !fetch_valid);

    // R5
    next_step_chk: assert property (@(posedge clk) disable iff (rst)
        rec_done_valid && rec_done_ready |=> fetch_valid || list_done);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        list_done |=> !list_done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        list_done |-> !busy && !fetch_valid);

    // R9
    err_nofetch_chk: assert property (@(posedge clk) disable iff (rst)
        list_err |-> !fetch_valid && !busy);

    // R10
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy && start |=> !list_err);

endmodule

bind trs_list_seq trs_list_seq_chk #(.ADDR_W(ADDR_W)) i_trs_chk (
    .clk            (clk),
    .rst            (rst),
    .start          (start),
    .fetch_valid    (fetch_valid),
    .fetch_ready    (fetch_ready),
    .fetch_addr     (fetch_addr),
    .resp_addr      (resp_addr),
    .rec_done_valid (rec_done_valid),
    .rec_done_ready (rec_done_ready),
    .busy           (busy),
    .list_done      (list_done),
    .list_err       (list_err)
);

// File: tb/test_trs_list_seq.sv
`timescale 1ns/1ps
module test_trs_list_seq;

    localparam int AW = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [31:0]   hdr_w0 = '0;
    logic [2:0]    size_code = '0;
    logic [AW-1:0] desc_base = '0;
    logic          fetch_valid;
    logic          fetch_ready = 1'b0;
    logic [AW-1:0] fetch_addr;
    logic [13:0]   fetch_idx;
    logic [AW-1:0] resp_addr;
    logic          rec_done_valid = 1'b0;
    logic          rec_done_ready;
    logic          busy;
    logic          list_done;
    logic          list_err;

    int checks = 0;
    int failures = 0;
    int exp_q[$];

    always #10 clk = ~clk;

    trs_list_seq #(.ADDR_W(AW)) i_trs_list_seq (
        .clk(clk), .rst(rst), .start(start), .hdr_w0(hdr_w0),
        .size_code(size_code), .desc_base(desc_base),
        .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
        .fetch_addr(fetch_addr), .fetch_idx(fetch_idx), .resp_addr(resp_addr),
        .rec_done_valid(rec_done_valid), .rec_done_ready(rec_done_ready),
        .busy(busy), .list_done(list_done), .list_err(list_err)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // per-clock reference check: fetch and done phases never overlap
    always @(negedge clk) begin
        if (!rst) chk("R4 phase overlap", longint'(fetch_valid && rec_done_ready), 0);
    end

    function automatic logic [31:0] mk_hdr(input int kind, input int rcnt, input int ridx, input int last);
        return {kind[1:0], 1'b0, rcnt[8:0], ridx[5:0], last[13:0]};
    endfunction

    // behavioural order of record visits
    task automatic build(input int last, input int ridx, input int rcnt, input int endless_passes);
        int reloads;
        exp_q.delete();
        for (int k = 0; k <= last; k++) exp_q.push_back(k);
        reloads = (rcnt == 511) ? endless_passes : rcnt;
        for (int p = 0; p < reloads; p++)
            for (int k = ridx; k <= last; k++) exp_q.push_back(k);
    endtask

    task automatic launch(input int kind, input int code, input int last, input int ridx,
                          input int rcnt, input longint b);
        @(negedge clk);
        hdr_w0    = mk_hdr(kind, rcnt, ridx, last);
        size_code = code[2:0];
        desc_base = b[AW-1:0];
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
    endtask

    task automatic serve(input longint b, input int code, input int last, input int gap,
                         input bit finite, input bit stray);
        longint sz;
        int k;
        int n;
        sz = longint'(16) << code;
        n = exp_q.size();
        for (int i = 0; i < n; i++) begin
            k = exp_q.pop_front();
            while (!fetch_valid) @(negedge clk);
            if (stray && i == 0) begin
                hdr_w0 = mk_hdr(1, 0, 0, 0);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                chk("R10 start while busy no err", longint'(list_err), 0);
                chk("R10 still requesting", longint'(fetch_valid), 1);
            end
            for (int g = 0; g < gap; g++) @(negedge clk);
            chk("R5 index order", longint'(fetch_idx), k);
            chk("R2 record address", longint'(fetch_addr), (b + sz * (k + 1)) & 40'hFF_FFFF_FFFF);
            chk("R3 response address", longint'(resp_addr),
                (b + sz * (last + 2) + 4 * k) & 40'hFF_FFFF_FFFF);
            fetch_ready = 1'b1;
            @(negedge clk);
            fetch_ready = 1'b0;
            chk("R4 waiting for done", longint'(rec_done_ready), 1);
            for (int g = 0; g < gap; g++) @(negedge clk);
            chk("R4 no second fetch in flight", longint'(fetch_valid), 0);
            rec_done_valid = 1'b1;
            @(negedge clk);
            rec_done_valid = 1'b0;
            if (finite && i == n - 1) begin
                chk("R8 done pulse", longint'(list_done), 1);
                chk("R8 idle at done", longint'(busy), 0);
                @(negedge clk);
                chk("R8 done one cycle", longint'(list_done), 0);
            end else begin
                chk("R6 no early done", longint'(list_done), 0);
            end
        end
    endtask

    task automatic bad_start(input int kind, input int code, input string tag);
        launch(kind, code, 2, 0, 0, 64'h4000);
        chk({tag, " err pulse"}, longint'(list_err), 1);
        chk({tag, " no fetch"}, longint'(fetch_valid), 0);
        @(negedge clk);
        chk({tag, " err one cycle"}, longint'(list_err), 0);
        chk({tag, " still idle"}, longint'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 busy", longint'(busy), 0);
        chk("R1 fetch_valid", longint'(fetch_valid), 0);
        chk("R1 rec_done_ready", longint'(rec_done_ready), 0);
        chk("R1 pulses", longint'({list_done, list_err}), 0);

        // R2 R5: plain list, no reload, 16-byte records
        build(3, 0, 0, 0);
        launch(3, 0, 3, 0, 0, 64'h1000);
        serve(64'h1000, 0, 3, 0, 1, 0);

        // R6: reload to a middle index twice, 32-byte records, stalls, stray start (R10)
        build(4, 2, 2, 0);
        launch(3, 1, 4, 2, 2, 64'h2_0000);
        serve(64'h2_0000, 1, 4, 2, 1, 1);

        // R6: single-record list repeated, 128-byte records
        build(0, 0, 3, 0);
        launch(3, 3, 0, 0, 3, 64'h500);
        serve(64'h500, 3, 0, 1, 1, 0);

        // R6: reload index equal to last index, 64-byte records, high base
        build(2, 2, 1, 0);
        launch(3, 2, 2, 2, 1, 64'h30_0000_0040);
        serve(64'h30_0000_0040, 2, 2, 0, 1, 0);

        // R7: endless count, three reload passes then reset
        build(2, 1, 511, 3);
        launch(3, 0, 2, 1, 511, 64'h800);
        serve(64'h800, 0, 2, 1, 0, 0);
        repeat (2) @(negedge clk);
        chk("R7 endless keeps fetching", longint'(fetch_valid), 1);
        chk("R7 endless never done", longint'(list_done), 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle after reset", longint'({busy, fetch_valid, rec_done_ready}), 0);

        // R9: wrong type, reserved bit, oversize code
        bad_start(1, 0, "R9 type");
        launch(3, 0, 2, 0, 0, 64'h4000);
        hdr_w0 = '0;
        chk("R2 good start busy", longint'(busy), 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        bad_start(2, 0, "R9 type2");
        bad_start(3, 5, "R9 size code");
        @(negedge clk);
        hdr_w0 = mk_hdr(3, 0, 0, 1) | 32'h2000_0000;
        size_code = 3'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 reserved bit err", longint'(list_err), 1);
        chk("R9 reserved bit no fetch", longint'(fetch_valid), 0);

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule